// File: doc/BRIEF.md
# Dual Programmable Down-Counter Timer

This block holds a pair of 32-bit down-counting timers that software reaches through one shared register window. Each timer has a live count, a reload value and a control word. The control word selects whether the timer runs, whether it stops or restarts when it expires, and how often it steps: on every clock, or on every second, fourth or eighth clock. When a running timer expires it sends a one-cycle pulse on its own interrupt line.

Every bus write comes with a privilege flag. A write marked as user level changes nothing and raises a one-cycle fault pulse. Reads are allowed at any privilege level and return the current state of the registers, including the count as it runs. A timer that is stopped keeps its count, and counting carries on from that value when the timer is started again.

Top module: `dual_timer_unit`

## Requirements
- R1: After reset every count, reload and control register reads zero, and every interrupt line and the fault output are low.
- R2: Timer k starts at byte address 16*k. Its count register is at offset 0x0, its reload register at 0x4 and its control register at 0x8. Offset 0xC reads zero and ignores writes. An address whose two low bits are not zero reads zero and writes nothing. Control bit 0 is run, bit 1 is auto-restart, and bits 3:2 are the rate code.
- R3: A running timer with rate code r decrements once every 2^r clocks. After the write that starts it with count N, its interrupt arrives exactly N*2^r clocks later.
- R4: Each timer has its own interrupt bit. It goes high for exactly one cycle when the count expires, that is, when a step is taken from a count of 1.
- R5: In single-shot mode (auto-restart = 0), expiry leaves the count at 0 and clears the run bit, and no further interrupts follow. A timer that is running with a count of 0 raises no interrupt.
- R6: In auto-restart mode, expiry loads the count from the reload register. The next interrupt then follows reload*2^r clocks later.
- R7: Clearing the run bit freezes the count. Setting it again resumes counting from the frozen value.
- R8: A write with the user flag set changes no register. It raises the fault output for exactly the one cycle after the write. A write at supervisor level raises no fault.
- R9: Reads work at any privilege level and return the current count.
- R10: Writing to or running one timer has no effect on the other timer's registers or interrupt line.
- R11: A write to the count register takes priority over a decrement in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Byte address into the register window |
| bus_wdata | input | 32 | Write data |
| bus_user | input | 1 | High when the write comes from user privilege |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| tmr_irq | output | NUM_TMR | One expiry pulse line per timer |
| priv_fault | output | 1 | One-cycle pulse after a refused user write |

## Verification
If a prescaler phase is wrong, the interrupt arrives off the expected N*2^r cycle count, and this already shows at the first expiry of a vector. If the count or reload state is wrong, the count that reads back right after expiry is wrong, or the second auto-restart period has the wrong length. If the privilege gating is wrong, a supervisor readback in the cycle after the refused write shows the changed value. If the enable handling is wrong, two reads of a stopped timer taken a few cycles apart differ.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   localparam int RATE_W = 2;

   typedef struct packed {
      logic [RATE_W-1:0] rate;
      logic              restart;
      logic              run;
   } tmr_ctrl_t;

   localparam int CTRL_W = $bits(tmr_ctrl_t);

   typedef enum logic [1:0] {
      REG_COUNT  = 2'd0,
      REG_RELOAD = 2'd1,
      REG_CTRL   = 2'd2,
      REG_SPARE  = 2'd3
   } tmr_reg_e;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
   import tmr_pkg::*;
#(
   parameter int DIV_BITS = (1 << RATE_W) - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              restart_phase,
   input  logic [RATE_W-1:0] rate,
   output logic              tick
);
   localparam int MAX_CODE = (1 << RATE_W) - 1;

   logic [DIV_BITS-1:0] phase_q;
   logic [DIV_BITS-1:0] limit;

   initial begin
      assert (DIV_BITS >= MAX_CODE) else $error("prescaler too narrow for rate code");
   end

   assign limit = DIV_BITS'((32'd1 << rate) - 32'd1);
   assign tick  = run && (phase_q == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= '0;
      end else if (restart_phase || !run || tick) begin
         phase_q <= '0;
      end else begin
         phase_q <= phase_q + 1'b1;
      end
   end

   AST_PHASE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      phase_q <= limit || $past(restart_phase) || !$past(run) || $changed(rate)) else $error("phase overran"); // R3
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
   import tmr_pkg::*;
#(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_cnt,
   input  logic             wr_rld,
   input  logic             wr_ctrl,
   input  logic [CNT_W-1:0] wval,
   input  tmr_ctrl_t        wctrl,
   output logic [CNT_W-1:0] cnt_o,
   output logic [CNT_W-1:0] rld_o,
   output tmr_ctrl_t        ctrl_o,
   output logic             irq_o
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q, rld_q;
   tmr_ctrl_t        ctrl_q;
   logic             irq_q;
   logic             tick;
   logic             expire;

   initial begin
      assert (CNT_W >= 2 && CNT_W <= 32) else $error("CNT_W out of range");
   end

   tmr_prescaler u_psc (
      .clk           (clk),
      .rst_n         (rst_n),
      .run           (ctrl_q.run),
      .restart_phase (wr_ctrl),
      .rate          (ctrl_q.rate),
      .tick          (tick)
   );

   assign expire = tick && !wr_cnt && (cnt_q == ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         rld_q  <= '0;
         ctrl_q <= '0;
         irq_q  <= 1'b0;
      end else begin
         irq_q <= expire;
         if (wr_rld) rld_q <= wval;
         if (wr_cnt) begin
            cnt_q <= wval;
         end else if (tick && cnt_q != '0) begin
            if (cnt_q == ONE) cnt_q <= ctrl_q.restart ? rld_q : '0;
            else              cnt_q <= cnt_q - ONE;
         end
         if (wr_ctrl) begin
            ctrl_q <= wctrl;
         end else if (expire && !ctrl_q.restart) begin
            ctrl_q.run <= 1'b0;
         end
      end
   end

   assign cnt_o  = cnt_q;
   assign rld_o  = rld_q;
   assign ctrl_o = ctrl_q;
   assign irq_o  = irq_q;

   AST_IRQ_FROM_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q |-> $past(cnt_q) == ONE) else $error("irq without count of one"); // R4
   AST_SINGLE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_q && !ctrl_q.restart && !$past(wr_ctrl)) |-> !ctrl_q.run) else $error("single shot kept running"); // R5
   AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(ctrl_q.run) && !$past(wr_cnt)) |-> cnt_q == $past(cnt_q)) else $error("stopped count moved"); // R7
   AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(wr_ctrl) && !irq_q) |-> ctrl_q == $past(ctrl_q)) else $error("control changed unasked"); // R5
endmodule

// File: rtl/dual_timer_unit.sv
module dual_timer_unit
   import tmr_pkg::*;
#(
   parameter int NUM_TMR = 2,
   parameter int CNT_W   = 32,
   parameter int ADDR_W  = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_wr,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [31:0]        bus_wdata,
   input  logic               bus_user,
   output logic [31:0]        bus_rdata,
   output logic [NUM_TMR-1:0] tmr_irq,
   output logic               priv_fault
);
   localparam int DATA_W = 32;
   localparam int SEL_W  = (NUM_TMR > 1) ? $clog2(NUM_TMR) : 1;

   initial begin
      assert (NUM_TMR >= 2) else $error("NUM_TMR must be at least 2");
      assert (ADDR_W >= 4 + SEL_W) else $error("ADDR_W too small for timer count");
      assert (CNT_W <= DATA_W) else $error("CNT_W wider than bus");
   end

   logic [CNT_W-1:0] cnt_a  [NUM_TMR];
   logic [CNT_W-1:0] rld_a  [NUM_TMR];
   tmr_ctrl_t        ctrl_a [NUM_TMR];

   logic [SEL_W-1:0] tsel;
   tmr_reg_e         rsel;
   logic             aligned;
   logic             wr_ok;
   logic             fault_q;

   assign tsel    = bus_addr[4 +: SEL_W];
   assign rsel    = tmr_reg_e'(bus_addr[3:2]);
   assign aligned = (bus_addr[1:0] == 2'b00);
   assign wr_ok   = bus_wr && !bus_user && aligned;

   for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
      logic hit;
      assign hit = wr_ok && (tsel == SEL_W'(i));

      tmr_channel #(.CNT_W(CNT_W)) u_chan (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_cnt  (hit && rsel == REG_COUNT),
         .wr_rld  (hit && rsel == REG_RELOAD),
         .wr_ctrl (hit && rsel == REG_CTRL),
         .wval    (bus_wdata[CNT_W-1:0]),
         .wctrl   (tmr_ctrl_t'(bus_wdata[CTRL_W-1:0])),
         .cnt_o   (cnt_a[i]),
         .rld_o   (rld_a[i]),
         .ctrl_o  (ctrl_a[i]),
         .irq_o   (tmr_irq[i])
      );

      AST_USER_RLD_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
         $past(bus_wr && bus_user) |-> rld_a[i] == $past(rld_a[i])) else $error("user write changed reload"); // R8
   end

   always_comb begin
      bus_rdata = '0;
      if (aligned && (int'(tsel) < NUM_TMR)) begin
         unique case (rsel)
            REG_COUNT:  bus_rdata = DATA_W'(cnt_a[tsel]);
            REG_RELOAD: bus_rdata = DATA_W'(rld_a[tsel]);
            REG_CTRL:   bus_rdata = DATA_W'(ctrl_a[tsel]);
            REG_SPARE:  bus_rdata = '0;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) fault_q <= 1'b0;
      else        fault_q <= bus_wr && bus_user;
   end

   assign priv_fault = fault_q;

   AST_FAULT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      priv_fault |-> $past(bus_wr && bus_user)) else $error("fault without user write"); // R8
   AST_FAULT_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_user) |=> priv_fault) else $error("user write not flagged"); // R8
endmodule

// File: tb/test_dual_timer_unit.sv
module test_dual_timer_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic        bus_user = 1'b0;
   logic [31:0] bus_rdata;
   logic [1:0]  tmr_irq;
   logic        priv_fault;

   int checks = 0;
   int errs = 0;

   always #5 clk = ~clk;

   dual_timer_unit i_dual_timer_unit (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_user(bus_user), .bus_rdata(bus_rdata),
      .tmr_irq(tmr_irq), .priv_fault(priv_fault)
   );

   // vectors: timer, rate, auto-restart, start count, reload, first period, second period
   localparam int NV = 6;
   localparam int V_T  [NV] = '{0, 1, 0, 1, 0, 1};
   localparam int V_R  [NV] = '{0, 1, 2, 3, 1, 0};
   localparam int V_A  [NV] = '{0, 0, 0, 0, 1, 1};
   localparam int V_N  [NV] = '{5, 3, 4, 2, 3, 1};
   localparam int V_L  [NV] = '{9, 7, 0, 0, 4, 2};
   localparam int V_P1 [NV] = '{5, 6, 16, 16, 6, 1};
   localparam int V_P2 [NV] = '{0, 0, 0, 0, 8, 2};

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d, input logic user);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_user = user; bus_wr = 1'b1;
      @(posedge clk);
      @(negedge clk);
      bus_wr = 1'b0; bus_user = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [31:0] d);
      bus_addr = a; bus_user = 1'b1;
      #1 d = bus_rdata;
      bus_user = 1'b0;
   endtask

   task automatic wait_irq(input int t, output int c, output bit other);
      c = 0; other = 0;
      while (c < 300) begin
         @(negedge clk);
         c++;
         if (tmr_irq[1-t]) other = 1;
         if (tmr_irq[t]) break;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errs++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
      $finish;
   end

   initial begin
      logic [31:0] d, v1, v2;
      int c;
      bit other;
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 irq", 32'(tmr_irq), 0);
      check("R1 fault", 32'(priv_fault), 0);
      rst_n = 1'b1;
      @(negedge clk);
      for (int t = 0; t < 2; t++) begin
         for (int r = 0; r < 3; r++) begin
            rd(5'(t * 16 + r * 4), d);
            check("R1 register zero", d, 0);
         end
      end

      // table of timer vectors: R3 R4 R5 R6 R10
      for (int i = 0; i < NV; i++) begin
         logic [4:0] b;
         b = 5'(V_T[i] * 16);
         wr(b + 5'd4, 32'(V_L[i]), 1'b0);
         wr(b, 32'(V_N[i]), 1'b0);
         wr(b + 5'd8, 32'((V_R[i] << 2) | (V_A[i] << 1) | 1), 1'b0);
         wait_irq(V_T[i], c, other);
         check($sformatf("R3 first period v%0d", i), 32'(c), 32'(V_P1[i]));
         check($sformatf("R10 other irq quiet v%0d", i), 32'(other), 0);
         if (V_A[i] == 0) begin
            rd(b, d);
            check("R5 count zero after expiry", d, 0);
            rd(b + 5'd8, d);
            check("R5 run bit cleared", d, 32'(V_R[i] << 2));
            @(negedge clk);
            check("R4 one-cycle pulse", 32'(tmr_irq[V_T[i]]), 0);
            repeat (20) @(negedge clk);
            check("R5 no further irq", 32'(tmr_irq), 0);
         end else begin
            rd(b, d);
            check("R6 count reloaded", d, 32'(V_L[i]));
            wait_irq(V_T[i], c, other);
            check($sformatf("R6 second period v%0d", i), 32'(c), 32'(V_P2[i]));
            wr(b + 5'd8, 0, 1'b0);
         end
      end

      // R5 zero count raises nothing
      wr(5'h00, 0, 1'b0);
      wr(5'h08, 32'h1, 1'b0);
      repeat (20) @(negedge clk);
      check("R5 zero count no irq", 32'(tmr_irq), 0);
      wr(5'h08, 0, 1'b0);

      // R8 privilege
      wr(5'h04, 32'h1234, 1'b0);
      check("R8 no fault on supervisor write", 32'(priv_fault), 0);
      wr(5'h04, 32'hFFFF, 1'b1);
      check("R8 fault raised", 32'(priv_fault), 1);
      @(negedge clk);
      check("R8 fault one cycle", 32'(priv_fault), 0);
      rd(5'h04, d);
      check("R8 reload kept", d, 32'h1234);
      wr(5'h00, 32'd40, 1'b0);
      wr(5'h08, 32'h1, 1'b1);
      repeat (5) @(negedge clk);
      rd(5'h00, d);
      check("R8 user enable refused", d, 40);
      rd(5'h08, d);
      check("R8 control kept", d, 0);

      // R2 map details
      wr(5'h18, 32'hE, 1'b0);
      rd(5'h18, d);
      check("R2 control field readback", d, 32'hE);
      wr(5'h1C, 32'h55, 1'b0);
      rd(5'h1C, d);
      check("R2 spare offset reads zero", d, 0);
      wr(5'h11, 32'h77, 1'b0);
      rd(5'h10, d);
      check("R2 misaligned write ignored", d, 32'd2);
      rd(5'h11, d);
      check("R2 misaligned read zero", d, 0);

      // R7 freeze and resume, R9 live count
      wr(5'h00, 32'd100, 1'b0);
      wr(5'h08, 32'h1, 1'b0);
      repeat (10) @(negedge clk);
      rd(5'h00, d);
      check("R9 live count", d, 90);
      wr(5'h08, 32'h0, 1'b0);
      rd(5'h00, v1);
      repeat (10) @(negedge clk);
      rd(5'h00, v2);
      check("R7 frozen", v2, v1);
      wr(5'h08, 32'h1, 1'b0);
      repeat (5) @(negedge clk);
      rd(5'h00, d);
      check("R7 resumed from frozen value", d, v1 - 5);
      // R11 write wins over decrement
      wr(5'h00, 32'd50, 1'b0);
      rd(5'h00, d);
      check("R11 count write priority", d, 50);
      wr(5'h08, 32'h0, 1'b0);
      // R10 timer 1 untouched by timer 0 activity
      rd(5'h10, d);
      check("R10 other count intact", d, 2);
      rd(5'h14, d);
      check("R10 other reload intact", d, 2);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
      $finish;
   end
endmodule